// File: doc/BRIEF.md
# Bus Word Register with Gated Read

This block holds one data word for a shared bus. A write strobe captures the word on the bus at a rising clock edge. A read strobe places the stored word back on the bus. The read path is chosen at elaboration time. In the combinational form, the stored word appears on the bus output in the same cycle the read strobe rises. In the clocked form, the bus output is a register that loads the stored word at the edge where the read strobe is high.

A separate observation port always carries the stored word, whatever the read strobe is doing. A bus master must never raise both strobes in one cycle. If it does, the write still lands and the read is dropped. A one-cycle clash flag then goes high after that edge.

The reset is synchronous and active high.

Top module: `bus_word_reg`

## Requirements
- R1: An edge with `rst` high clears the stored word, the clocked bus output and `clash` to zero, whatever the strobes are.
- R2: An edge with `wr_en` high and `rst` low stores `bus_in`. `peek` shows the new word from just after that edge and not before it.
- R3: An edge with `wr_en` low and `rst` low leaves the stored word unchanged.
- R4: `peek` equals the stored word at all times, including while `rd_en` is high.
- R5: Combinational form (`READ_CLOCKED`=0): while `rd_en`=1 and `wr_en`=0, `bus_out` equals the stored word in the same cycle, with no edge needed.
- R6: Combinational form: while `rd_en`=0, `bus_out` is all zeros.
- R7: Clocked form (`READ_CLOCKED`=1): an edge with `rd_en`=1 and `wr_en`=0 loads `bus_out` with the word stored before that edge.
- R8: Clocked form: an edge with `rd_en`=0 leaves `bus_out` unchanged.
- R9: When `wr_en`=1 and `rd_en`=1 in one cycle, three things happen.
  - The write is performed.
  - The read is suppressed: `bus_out` is zero in the combinational form, and is held in the clocked form.
  - `clash` reads 1 for the cycle after that edge.
- R10: After any edge with `rst` low where the strobes were not both high, `clash` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| bus_in | input | DATA_W | Word to store |
| bus_out | output | DATA_W | Read data toward the bus |
| peek | output | DATA_W | Stored word, always visible |
| clash | output | 1 | Both strobes were high in the previous cycle |

## Verification
Both read forms are built side by side and driven with identical strobes. This exposes three kinds of error:
- a clocked read that captures the word written at the same edge instead of the old word;
- a combinational read that lags by a cycle;
- an idle bus output that is not zero.

Clash cycles are issued back to back and then singly. A flag that latches, or one that misses the second clash, shows up as a mismatch. The bench also checks that the store still takes the clashing write and that the read stays suppressed. A reset is issued in the middle of the run after a read has loaded the clocked output. A design that forgot to clear that output would keep showing stale data.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_READ  = 2'b10,
    ACC_CLASH = 2'b11
  } acc_kind_t;

  function automatic acc_kind_t classify(input logic wr, input logic rd);
    return acc_kind_t'({rd, wr});
  endfunction
endpackage

// File: rtl/bwr_store.sv
module bwr_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (rst)        word_q <= '0;
    else if (wr_en) word_q <= bus_in;
  end
endmodule

// File: rtl/bwr_read_port.sv
module bwr_read_port
  import bwr_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter bit READ_CLOCKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_kind_t         kind,
  input  logic [DATA_W-1:0] word_q,
  output logic [DATA_W-1:0] rd_data
);
  logic read_ok;
  assign read_ok = (kind == ACC_READ);

  generate
    if (READ_CLOCKED) begin : g_clocked
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
        if (rst)          rd_q <= '0;
        else if (read_ok) rd_q <= word_q;
      end
      assign rd_data = rd_q;
    end else begin : g_comb
      // The clock and reset are unused in this form, so they are folded in here.
      logic unused_in;
      assign unused_in = clk ^ rst;
      assign rd_data = read_ok ? word_q : '0;
    end
  endgenerate
endmodule

// File: rtl/bwr_guard.sv
module bwr_guard
  import bwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  acc_kind_t kind,
  output logic      clash_q
);
  always_ff @(posedge clk) begin
    if (rst) clash_q <= 1'b0;
    else     clash_q <= (kind == ACC_CLASH);
  end
endmodule

// File: rtl/bus_word_reg.sv
module bus_word_reg
  import bwr_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter bit READ_CLOCKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] peek,
  output logic              clash
);
  acc_kind_t         kind;
  logic [DATA_W-1:0] word_q;

  assign kind = classify(wr_en, rd_en);
  assign peek = word_q;

  bwr_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .bus_in(bus_in), .word_q(word_q)
  );

  bwr_read_port #(.DATA_W(DATA_W), .READ_CLOCKED(READ_CLOCKED)) u_rd (
    .clk(clk), .rst(rst), .kind(kind), .word_q(word_q), .rd_data(bus_out)
  );

  bwr_guard u_guard (
    .clk(clk), .rst(rst), .kind(kind), .clash_q(clash)
  );
endmodule

// File: rtl/bus_word_reg_chk.sv
module bus_word_reg_chk #(
  parameter int DATA_W       = 8,
  parameter bit READ_CLOCKED = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] bus_in,
  input logic [DATA_W-1:0] bus_out,
  input logic [DATA_W-1:0] peek,
  input logic              clash
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (peek == '0 && !clash)); // R1
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (peek == $past(bus_in))); // R2
  AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(peek)); // R3
  AST_CLASH_RAISED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> clash); // R9
  AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en) |=> !clash); // R10

  generate
    if (READ_CLOCKED) begin : g_clk_chk
      AST_CLK_READ_OLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |=> (bus_out == $past(peek))); // R7
      AST_CLK_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(bus_out)); // R8
      AST_CLK_CLASH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |=> $stable(bus_out)); // R9
    end else begin : g_comb_chk
      AST_COMB_READ_NOW: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en) |-> (bus_out == peek)); // R5
      AST_COMB_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (bus_out == '0)); // R6
      AST_COMB_CLASH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en) |-> (bus_out == '0)); // R9
    end
  endgenerate
endmodule

bind bus_word_reg bus_word_reg_chk #(.DATA_W(DATA_W), .READ_CLOCKED(READ_CLOCKED)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bus_in(bus_in),
  .bus_out(bus_out), .peek(peek), .clash(clash)
);

// File: tb/bus_word_reg_test.sv
`timescale 1ns/1ps
module bus_word_reg_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] out_a, peek_a, out_c, peek_c;
  logic       clash_a, clash_c;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] m_word = 8'h00;
  logic [7:0] m_rd   = 8'h00;
  logic       m_clash = 1'b0;

  always #2 clk = ~clk;

  bus_word_reg #(.DATA_W(8), .READ_CLOCKED(1'b0)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bus_in(bus_in),
    .bus_out(out_a), .peek(peek_a), .clash(clash_a)
  );

  bus_word_reg #(.DATA_W(8), .READ_CLOCKED(1'b1)) uut_clk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bus_in(bus_in),
    .bus_out(out_c), .peek(peek_c), .clash(clash_c)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive the inputs, check same-cycle outputs, take the edge,
  // update the model, then check the registered outputs.
  task automatic cyc(input logic r, input logic w, input logic o, input logic [7:0] d);
    logic [7:0] exp_a;
    rst = r; wr_en = w; rd_en = o; bus_in = d;
    #1;
    if (!r) begin
      exp_a = (o && !w) ? m_word : 8'h00;
      chk((o && !w) ? "R5 comb read" : (o && w) ? "R9 comb suppress" : "R6 comb idle",
          out_a, exp_a);
      chk("R4 peek", peek_a, m_word);
      chk("R4 peek clk", peek_c, m_word);
    end
    @(posedge clk);
    if (r) begin
      m_word = 8'h00; m_rd = 8'h00; m_clash = 1'b0;
    end else begin
      m_clash = w && o;
      if (o && !w) m_rd = m_word;
      if (w) m_word = d;
    end
    @(negedge clk);
    if (r) begin
      chk("R1 word", peek_a, 8'h00);
      chk("R1 clk out", out_c, 8'h00);
      chk("R1 clash", {7'd0, clash_a}, 8'h00);
      chk("R1 clash clk", {7'd0, clash_c}, 8'h00);
    end else begin
      chk(w ? "R2 write" : "R3 hold", peek_a, m_word);
      chk(w ? "R2 write clk" : "R3 hold clk", peek_c, m_word);
      chk((o && !w) ? "R7 clk read" : (o && w) ? "R9 clk suppress" : "R8 clk idle",
          out_c, m_rd);
      chk(m_clash ? "R9 clash" : "R10 quiet", {7'd0, clash_a}, {7'd0, m_clash});
      chk(m_clash ? "R9 clash clk" : "R10 quiet clk", {7'd0, clash_c}, {7'd0, m_clash});
    end
  endtask

  initial begin
    @(negedge clk);
    cyc(1, 0, 0, 8'h00);
    cyc(1, 1, 1, 8'hEE);          // R1: reset overrides both strobes
    cyc(0, 0, 1, 8'h11);          // read of the cleared word
    cyc(0, 1, 0, 8'hA5);          // R2 write
    cyc(0, 0, 0, 8'h5A);          // R3 hold, R6 idle
    cyc(0, 0, 1, 8'h00);          // R5 and R7 read
    cyc(0, 0, 0, 8'h00);          // R8: the clocked output holds
    cyc(0, 1, 0, 8'hFF);
    cyc(0, 1, 0, 8'h3C);          // back-to-back writes
    cyc(0, 0, 1, 8'h00);
    cyc(0, 0, 1, 8'h00);
    cyc(0, 1, 1, 8'h81);          // R9 clash
    cyc(0, 1, 1, 8'h42);          // second clash in a row
    cyc(0, 0, 0, 8'h00);          // R10: the flag drops
    cyc(0, 0, 1, 8'h00);
    cyc(0, 1, 0, 8'h00);          // write zero
    cyc(0, 1, 1, 8'h99);          // single clash
    cyc(0, 0, 1, 8'h00);
    cyc(0, 1, 0, 8'h77);
    cyc(0, 0, 1, 8'h00);
    cyc(1, 0, 0, 8'h00);          // R1: mid-run reset clears the loaded output
    cyc(0, 0, 0, 8'h00);
    cyc(0, 0, 1, 8'h00);
    for (int i = 0; i < 40; i++) begin
      cyc(0, i[0] ^ i[2], i[1] | (i[3] & i[0]), 8'(i * 37 + 5));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule